// File: doc/BRIEF.md
# Up/Bidirectional Event Tally with Status Flags

This block keeps a signed 16-bit hardware tally of single-cycle count strobes. A mode input selects one of two behaviours. In up-only mode every enabled strobe adds one, and the strobe that would bring the tally to the programmable high limit reloads it to zero instead. In bidirectional mode a direction input picks increment or decrement on each strobe, and the tally wraps freely across the signed range. Beside the live tally the block holds an image register, which is a snapshot that is refreshed on request and on every enabled cycle.

A 7-bit status word reports the live enables and several latched event flags. The latched flags are a limit-reached flag, an overflow flag and an underflow flag. The status word also echoes the snapshot request and carries a registered flag for "tally at or above the high limit". What each event flag means depends on the mode. In up mode, reaching the limit sets the done flag, and reaching it again while done is still set raises overflow. In bidirectional mode, overflow and underflow mark signed wraps in either direction. The at-or-above flag is only live in bidirectional mode. Software can preload it while counting is disabled. A flag-clear strobe drops the latched flags. A tally-reset strobe zeroes the tally, the image and all latched flags.

Top module: `updown_tally`

## Requirements
- R1: Status bit 0 (up-enable) equals `countEn` in the same cycle in both modes.
- R2: Status bit 1 (down-enable) equals `countEn` when `bidirMode`=1 and reads 0 when `bidirMode`=0.
- R3: With `bidirMode`=0, each cycle with `countEn`=1 and `countPulse`=1 adds one to `hwAcc`. If the incremented value would equal `highPreset`, `hwAcc` loads 0 instead and status bit 2 (done) sets and stays set. Done reads 0 when `bidirMode`=1.
- R4: With `bidirMode`=0, status bit 3 (overflow) sets on a limit-reaching count that happens while done is already set.
- R5: With `bidirMode`=1, an enabled strobe decrements `hwAcc` when `dirDown`=1 and increments it otherwise. Overflow (bit 3) sets on the step 16'h7FFF to 16'h8000. Underflow (bit 4) sets on the step 16'h8000 to 16'h7FFF. Underflow reads 0 when `bidirMode`=0.
- R6: On every cycle with `countEn`=1, status bit 6 (at-or-above) is loaded with the signed test "next `hwAcc` >= `highPreset`". It is visible only when `bidirMode`=1 and reads 0 otherwise.
- R7: With `countEn`=0, `cfgCmpWrite`=1 loads `cfgCmpValue` into the at-or-above flag. With `countEn`=1 the write is ignored.
- R8: `imageAcc` takes the pre-edge `hwAcc` on any cycle with `updateReq`=1 or `countEn`=1. Status bit 5 (update) echoes `updateReq`.
- R9: `accReset`=1 zeroes `hwAcc`, `imageAcc`, done, overflow and underflow at the next edge. A strobe in that cycle is not counted.
- R10: `flagClear`=1 clears done, overflow and underflow. A set event in the same cycle takes priority over the clear.
- R11: Strobes with `countEn`=0 leave `hwAcc` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bidirMode | input | 1 | 0 = up-only, 1 = bidirectional |
| countEn | input | 1 | Counter enable |
| countPulse | input | 1 | Single-cycle count strobe |
| dirDown | input | 1 | Bidirectional direction, 1 = decrement |
| highPreset | input | 16 | Signed high limit |
| updateReq | input | 1 | Snapshot request into the image |
| flagClear | input | 1 | Clears latched flags |
| accReset | input | 1 | Clears tally, image and latched flags |
| cfgCmpWrite | input | 1 | Preload strobe for the at-or-above flag |
| cfgCmpValue | input | 1 | Value preloaded into the at-or-above flag |
| hwAcc | output | 16 | Live hardware tally |
| imageAcc | output | 16 | Image (snapshot) tally |
| statusWord | output | 7 | {atOrAbove, update, underflow, overflow, done, downEn, upEn} |

## Verification
A wrong tally value shows on `hwAcc` one edge after the strobe that caused it. It also reaches `imageAcc` one edge later on any enabled cycle. A latched flag that sets or clears at the wrong time is visible on `statusWord` at the edge that follows the event, and because it is latched the error persists until the next clear. The bidirectional run walks the tally across both signed wrap points, so a wrong wrap compare fails within one cycle of the boundary. The up-mode runs use small limits, so a reload or done/overflow chaining fault appears within a few strobes.

// File: rtl/tally_pkg.sv
package tally_pkg;
  localparam int STATUS_W = 7;
  localparam int ST_UP_EN   = 0;
  localparam int ST_DOWN_EN = 1;
  localparam int ST_DONE    = 2;
  localparam int ST_OVER    = 3;
  localparam int ST_UNDER   = 4;
  localparam int ST_UPDATE  = 5;
  localparam int ST_AT_HIGH = 6;

  typedef struct packed {
    logic clrAcc;
    logic clrImg;
    logic stepUp;
    logic stepDown;
    logic reloadZero;
    logic copyImg;
  } dpStrobe_t;
endpackage

// File: rtl/tally_datapath.sv
module tally_datapath
  import tally_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [ACC_W-1:0] highPreset,
  output logic [ACC_W-1:0] hwAcc,
  output logic [ACC_W-1:0] imageAcc,
  output logic             atMaxPos,
  output logic             atMinNeg,
  output logic             hitPreset,
  output logic             geNext
);
  localparam logic [ACC_W-1:0] MAX_POS = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MIN_NEG = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] ONE     = {{(ACC_W-1){1'b0}}, 1'b1};

  logic [ACC_W-1:0] accPlus;
  logic [ACC_W-1:0] accMinus;
  logic [ACC_W-1:0] accNext;

  assign accPlus   = hwAcc + ONE;
  assign accMinus  = hwAcc - ONE;
  assign atMaxPos  = (hwAcc == MAX_POS);
  assign atMinNeg  = (hwAcc == MIN_NEG);
  assign hitPreset = (accPlus == highPreset);

  always_comb begin
    accNext = hwAcc;
    if (strobe.clrAcc || strobe.reloadZero) accNext = '0;
    else if (strobe.stepUp)                 accNext = accPlus;
    else if (strobe.stepDown)               accNext = accMinus;
  end

  assign geNext = ($signed(accNext) >= $signed(highPreset));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hwAcc    <= '0;
      imageAcc <= '0;
    end else begin
      hwAcc <= accNext;
      if (strobe.clrImg)       imageAcc <= '0;
      else if (strobe.copyImg) imageAcc <= hwAcc;
    end
  end
endmodule

// File: rtl/tally_control.sv
module tally_control
  import tally_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      bidirMode,
  input  logic      countEn,
  input  logic      countPulse,
  input  logic      dirDown,
  input  logic      updateReq,
  input  logic      flagClear,
  input  logic      accReset,
  input  logic      cfgCmpWrite,
  input  logic      cfgCmpValue,
  input  logic      atMaxPos,
  input  logic      atMinNeg,
  input  logic      hitPreset,
  input  logic      geNext,
  output dpStrobe_t strobe,
  output logic      doneQ,
  output logic      overQ,
  output logic      underQ,
  output logic      atHighQ
);
  logic counting;
  logic reachEv;
  logic overEv;
  logic underEv;

  assign counting = countEn && countPulse && !accReset;
  assign reachEv  = counting && !bidirMode && hitPreset;
  assign overEv   = (reachEv && doneQ) ||
                    (counting && bidirMode && !dirDown && atMaxPos);
  assign underEv  = counting && bidirMode && dirDown && atMinNeg;

  always_comb begin
    strobe            = '0;
    strobe.clrAcc     = accReset;
    strobe.clrImg     = accReset;
    strobe.copyImg    = updateReq || countEn;
    strobe.reloadZero = reachEv;
    strobe.stepUp     = counting && ((!bidirMode && !hitPreset) || (bidirMode && !dirDown));
    strobe.stepDown   = counting && bidirMode && dirDown;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneQ   <= 1'b0;
      overQ   <= 1'b0;
      underQ  <= 1'b0;
      atHighQ <= 1'b0;
    end else begin
      if (accReset)       doneQ <= 1'b0;
      else if (reachEv)   doneQ <= 1'b1;
      else if (flagClear) doneQ <= 1'b0;

      if (accReset)       overQ <= 1'b0;
      else if (overEv)    overQ <= 1'b1;
      else if (flagClear) overQ <= 1'b0;

      if (accReset)       underQ <= 1'b0;
      else if (underEv)   underQ <= 1'b1;
      else if (flagClear) underQ <= 1'b0;

      if (countEn)          atHighQ <= geNext;
      else if (cfgCmpWrite) atHighQ <= cfgCmpValue;
    end
  end
endmodule

// File: rtl/updown_tally.sv
module updown_tally
  import tally_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bidirMode,
  input  logic                countEn,
  input  logic                countPulse,
  input  logic                dirDown,
  input  logic [ACC_W-1:0]    highPreset,
  input  logic                updateReq,
  input  logic                flagClear,
  input  logic                accReset,
  input  logic                cfgCmpWrite,
  input  logic                cfgCmpValue,
  output logic [ACC_W-1:0]    hwAcc,
  output logic [ACC_W-1:0]    imageAcc,
  output logic [STATUS_W-1:0] statusWord
);
  dpStrobe_t strobe;
  logic atMaxPos, atMinNeg, hitPreset, geNext;
  logic doneQ, overQ, underQ, atHighQ;

  tally_control u_ctrl (
    .clk(clk), .rstN(rstN), .bidirMode(bidirMode), .countEn(countEn),
    .countPulse(countPulse), .dirDown(dirDown), .updateReq(updateReq),
    .flagClear(flagClear), .accReset(accReset), .cfgCmpWrite(cfgCmpWrite),
    .cfgCmpValue(cfgCmpValue), .atMaxPos(atMaxPos), .atMinNeg(atMinNeg),
    .hitPreset(hitPreset), .geNext(geNext), .strobe(strobe),
    .doneQ(doneQ), .overQ(overQ), .underQ(underQ), .atHighQ(atHighQ)
  );

  tally_datapath #(.ACC_W(ACC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .highPreset(highPreset),
    .hwAcc(hwAcc), .imageAcc(imageAcc), .atMaxPos(atMaxPos),
    .atMinNeg(atMinNeg), .hitPreset(hitPreset), .geNext(geNext)
  );

  always_comb begin
    statusWord             = '0;
    statusWord[ST_UP_EN]   = countEn;
    statusWord[ST_DOWN_EN] = countEn && bidirMode;
    statusWord[ST_DONE]    = doneQ && !bidirMode;
    statusWord[ST_OVER]    = overQ;
    statusWord[ST_UNDER]   = underQ && bidirMode;
    statusWord[ST_UPDATE]  = updateReq;
    statusWord[ST_AT_HIGH] = atHighQ && bidirMode;
  end
endmodule

// File: rtl/updown_tally_checker.sv
module updown_tally_checker
  import tally_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                bidirMode,
  input logic                countEn,
  input logic                countPulse,
  input logic                dirDown,
  input logic [ACC_W-1:0]    highPreset,
  input logic                updateReq,
  input logic                flagClear,
  input logic                accReset,
  input logic                cfgCmpWrite,
  input logic                cfgCmpValue,
  input logic [ACC_W-1:0]    hwAcc,
  input logic [ACC_W-1:0]    imageAcc,
  input logic [STATUS_W-1:0] statusWord
);
  localparam logic [ACC_W-1:0] MAX_POS = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MIN_NEG = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] ONE     = {{(ACC_W-1){1'b0}}, 1'b1};

  a_r2_down_en_masked: assert property (@(posedge clk) disable iff (!rstN)
    !bidirMode |-> !statusWord[ST_DOWN_EN]);

  a_r3_up_step: assert property (@(posedge clk) disable iff (!rstN)
    (!bidirMode && countEn && countPulse && !accReset && (hwAcc + ONE != highPreset))
    |=> hwAcc == $past(hwAcc) + ONE);

  a_r3_done_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!bidirMode && statusWord[ST_DONE] && !flagClear && !accReset)
    |=> (bidirMode || statusWord[ST_DONE]));

  a_r5_wrap_over: assert property (@(posedge clk) disable iff (!rstN)
    (bidirMode && countEn && countPulse && !dirDown && !accReset && hwAcc == MAX_POS)
    |=> (hwAcc == MIN_NEG && statusWord[ST_OVER]));

  a_r5_wrap_under: assert property (@(posedge clk) disable iff (!rstN)
    (bidirMode && countEn && countPulse && dirDown && !accReset && hwAcc == MIN_NEG)
    |=> (hwAcc == MAX_POS && (!bidirMode || statusWord[ST_UNDER])));

  a_r6_at_high_tracks: assert property (@(posedge clk) disable iff (!rstN)
    (bidirMode && countEn)
    |=> (!bidirMode || (statusWord[ST_AT_HIGH] == ($signed(hwAcc) >= $signed($past(highPreset))))));

  a_r8_image_copy: assert property (@(posedge clk) disable iff (!rstN)
    ((updateReq || countEn) && !accReset) |=> imageAcc == $past(hwAcc));

  a_r9_acc_reset: assert property (@(posedge clk) disable iff (!rstN)
    accReset |=> (hwAcc == '0 && imageAcc == '0 && !statusWord[ST_DONE] &&
                  !statusWord[ST_OVER] && !statusWord[ST_UNDER]));

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!countEn && !accReset) |=> $stable(hwAcc));
endmodule

bind updown_tally updown_tally_checker #(.ACC_W(ACC_W)) i_chk (.*);

// File: tb/test_updown_tally.sv
module test_updown_tally;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 120000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bidirMode = 1'b0, countEn = 1'b0, countPulse = 1'b0, dirDown = 1'b0;
  logic [15:0] highPreset = '0;
  logic updateReq = 1'b0, flagClear = 1'b0, accReset = 1'b0;
  logic cfgCmpWrite = 1'b0, cfgCmpValue = 1'b0;
  logic [15:0] hwAcc, imageAcc;
  logic [6:0] statusWord;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic signed [15:0] mAcc, mImg;
  logic mDone, mOver, mUnder, mHigh;

  always #(CLK_PERIOD/2) clk = ~clk;

  updown_tally i_updown_tally (
    .clk(clk), .rstN(rstN), .bidirMode(bidirMode), .countEn(countEn),
    .countPulse(countPulse), .dirDown(dirDown), .highPreset(highPreset),
    .updateReq(updateReq), .flagClear(flagClear), .accReset(accReset),
    .cfgCmpWrite(cfgCmpWrite), .cfgCmpValue(cfgCmpValue),
    .hwAcc(hwAcc), .imageAcc(imageAcc), .statusWord(statusWord)
  );

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic signed [15:0] nextAcc();
    logic signed [15:0] up1 = mAcc + 16'sd1;
    if (accReset) return 16'sd0;
    if (!(countEn && countPulse)) return mAcc;
    if (!bidirMode) return (up1 == $signed(highPreset)) ? 16'sd0 : up1;
    return dirDown ? mAcc - 16'sd1 : up1;
  endfunction

  task automatic modelReset();
    mAcc = 0; mImg = 0; mDone = 0; mOver = 0; mUnder = 0; mHigh = 0;
  endtask

  task automatic compareAll();
    check("R3/R5", "hwAcc", hwAcc, mAcc);
    check("R8", "imageAcc", imageAcc, mImg);
    check("R1", "upEn", {15'd0, statusWord[0]}, {15'd0, countEn});
    check("R2", "downEn", {15'd0, statusWord[1]}, {15'd0, countEn & bidirMode});
    check("R3", "done", {15'd0, statusWord[2]}, {15'd0, mDone & !bidirMode});
    check("R4/R5", "overflow", {15'd0, statusWord[3]}, {15'd0, mOver});
    check("R5", "underflow", {15'd0, statusWord[4]}, {15'd0, mUnder & bidirMode});
    check("R8", "update", {15'd0, statusWord[5]}, {15'd0, updateReq});
    check("R6/R7", "atHigh", {15'd0, statusWord[6]}, {15'd0, mHigh & bidirMode});
  endtask

  // inputs were set at a falling edge; compare, advance model, wait next falling edge
  task automatic tick();
    logic counting, reach, overE, underE;
    logic signed [15:0] nAcc;
    #1;
    compareAll();
    counting = countEn && countPulse && !accReset;
    reach  = counting && !bidirMode && ((mAcc + 16'sd1) == $signed(highPreset));
    overE  = (reach && mDone) || (counting && bidirMode && !dirDown && mAcc == 16'sh7FFF);
    underE = counting && bidirMode && dirDown && mAcc == -16'sd32768;
    nAcc = nextAcc();
    if (accReset) begin mDone = 0; mOver = 0; mUnder = 0; end
    else begin
      if (reach) mDone = 1; else if (flagClear) mDone = 0;
      if (overE) mOver = 1; else if (flagClear) mOver = 0;
      if (underE) mUnder = 1; else if (flagClear) mUnder = 0;
    end
    if (countEn) mHigh = (nAcc >= $signed(highPreset));
    else if (cfgCmpWrite) mHigh = cfgCmpValue;
    if (accReset) mImg = 0;
    else if (updateReq || countEn) mImg = mAcc;
    mAcc = nAcc;
    @(negedge clk);
  endtask

  task automatic idleInputs();
    countEn = 0; countPulse = 0; dirDown = 0; updateReq = 0;
    flagClear = 0; accReset = 0; cfgCmpWrite = 0; cfgCmpValue = 0;
  endtask

  task automatic restart(logic mode, logic [15:0] preset);
    @(negedge clk);
    idleInputs();
    rstN = 0; bidirMode = mode; highPreset = preset;
    modelReset();
    @(negedge clk);
    rstN = 1;
  endtask

  task automatic randomStim(int n, logic signed [15:0] lo, int span);
    for (int i = 0; i < n; i++) begin
      countEn     = ($urandom % 10) < 8;
      countPulse  = $urandom % 2;
      dirDown     = $urandom % 2;
      updateReq   = ($urandom % 10) == 0;
      flagClear   = ($urandom % 20) == 0;
      accReset    = ($urandom % 50) == 0;
      cfgCmpWrite = ($urandom % 10) == 0;
      cfgCmpValue = $urandom % 2;
      if (($urandom % 40) == 0) highPreset = lo + 16'($urandom % span);
      tick();
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    modelReset();
    repeat (3) @(negedge clk);
    // reset state
    check("R9", "reset hwAcc", hwAcc, 16'h0);
    check("R9", "reset status", {9'd0, statusWord}, 16'h0);
    rstN = 1;

    // R3/R4 up mode, limit 3: done on reach, overflow on second reach
    restart(1'b0, 16'd3);
    countEn = 1; countPulse = 1;
    repeat (8) tick();
    // R10 set wins over clear: clear on the reach cycle
    flagClear = 1; tick(); flagClear = 0; countPulse = 0; tick();
    countPulse = 1; flagClear = 1; tick(); tick(); tick();
    flagClear = 0; countPulse = 0; tick();
    // R11 strobes ignored while disabled
    countEn = 0; countPulse = 1; repeat (3) tick();
    // R9 reset with strobe present
    countEn = 1; accReset = 1; tick(); accReset = 0; tick();

    // R7 preload while disabled, ignored while enabled (bidirectional)
    restart(1'b1, 16'd5);
    cfgCmpWrite = 1; cfgCmpValue = 1; tick();
    cfgCmpWrite = 0; tick();
    countEn = 1; cfgCmpWrite = 1; cfgCmpValue = 1; tick();
    cfgCmpWrite = 0; tick();

    // R5 walk down through the negative wrap, then up through the positive wrap
    restart(1'b1, 16'd0);
    countEn = 1; countPulse = 1; dirDown = 1;
    for (int i = 0; i < 32769; i++) tick();
    dirDown = 0; tick(); tick();
    flagClear = 1; countPulse = 0; tick();
    flagClear = 0; tick();

    // random mixes
    restart(1'b0, 16'd4);
    randomStim(3000, 16'sd1, 8);
    restart(1'b1, 16'd0);
    randomStim(3000, -16'sd4, 9);
    restart(1'b0, 16'hFFFE);
    randomStim(1500, -16'sd3, 6);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule